// File: doc/BRIEF.md
# Delta Threshold-Crossing Spike Encoder

This block turns a stream of 8-bit sample values into spike vectors for a spiking network. Each sample is one time step. The block compares the new sample with the previous one, and it fires every channel whose threshold level falls inside the interval crossed by that change. It fires only the channels that match the direction of the change. Channels alternate by direction: even channels respond to rising values, odd channels respond to falling values. An input that stays at one level produces no spikes, whatever that level is.

A frame begins with a start-of-frame strobe, which also sets the remembered previous value to zero. Once the last sample of the sequence has been accepted, the encoder runs on by itself. On each of the remaining steps of the frame it fires a single end-marker channel, and it accepts no samples during that time. One clock after the final step it raises a one-cycle frame-done pulse. It then waits for the next start of frame.

Top module: `dspk_encoder`

## Requirements
- R1: After reset, `spk_valid`, `spk` and `frame_done` are 0, and the encoder stays idle. A sample presented before the first `sof` produces no step.
- R2: Channel k, for 0 <= k <= 78, owns threshold floor(k*256/79). Even k are rising channels and odd k are falling channels. Channel 79 is the end marker. A threshold counts as crossed when it is strictly greater than the lower of the two values and less than or equal to the higher one. As a result, channel 0 never fires.
- R3: When a sample is greater than the previous value, exactly the even channels with a crossed threshold fire, and channel 79 stays low.
- R4: When a sample is less than the previous value, exactly the odd channels with a crossed threshold fire.
- R5: A sample equal to the previous value gives a step with `spk_valid`=1 and an all-zero `spk`.
- R6: `sof` sets the previous value to 0. If `in_valid` is high in the same cycle as `sof`, that sample is the first of the frame and is compared against 0.
- R7: The spike vector for an accepted sample appears with `spk_valid`=1 in the clock cycle after the accepting edge. In any cycle without a step, `spk_valid` is 0 and `spk` is all-zero.
- R8: After the 784th sample, steps 785 through 840 follow on consecutive cycles. Each of these steps has only channel 79 set, and samples offered during this period are ignored.
- R9: `frame_done` is high for exactly one cycle, in the cycle after step 840. After that, samples are ignored until the next `sof`.
- R10: A `sof` in the middle of a frame restarts the step count and the previous value.
- R11: No step fires a rising channel and a falling channel together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start of frame; also sets the previous value to 0 |
| in_valid | input | 1 | A sample is offered in this cycle |
| in_sample | input | 8 | Sample value |
| spk_valid | output | 1 | `spk` holds one time step |
| spk | output | 80 | Spike vector, one bit per channel |
| frame_done | output | 1 | One-cycle pulse after the last step of the frame |

## Verification
Every output is registered. A step's spike vector is due one clock after the edge that accepted its sample, or, for a tail step, one clock after the edge at which the sequencer counted that step. `frame_done` is due one clock after the spike vector of step 840. The bench drives inputs on the falling edge and updates its expected values at that moment. At the next falling edge it compares all three outputs, before it drives anything new, so every check lands exactly one register stage after its stimulus.

// File: rtl/dspk_pkg.sv
package dspk_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_TAIL = 2'd2,
        SEQ_FIN  = 2'd3
    } seq_state_e;

    // Threshold level of ladder rung k, truncated.
    function automatic int unsigned rung_level(int unsigned k, int unsigned span, int unsigned rungs);
        return (k * span) / rungs;
    endfunction

endpackage

// File: rtl/dspk_ladder.sv
module dspk_ladder #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_LVL  = 79
) (
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic              up,
    output logic [N_LVL-1:0]  hit
);
    localparam int unsigned SPAN = 1 << DATA_W;

    // One comparator pair per rung; even rungs face upward, odd rungs downward.
    for (genvar k = 0; k < N_LVL; k++) begin : g_rung
        localparam int unsigned LV   = dspk_pkg::rung_level(k, SPAN, N_LVL);
        localparam logic [DATA_W:0] LV_W = LV[DATA_W:0];
        localparam bit   FACES_UP = ((k % 2) == 0);
        assign hit[k] = (up == FACES_UP) && (LV_W > {1'b0, lo}) && (LV_W <= {1'b0, hi});
    end

endmodule

// File: rtl/dspk_seq.sv
module dspk_seq
    import dspk_pkg::*;
#(
    parameter int unsigned SEQ_LEN     = 784,
    parameter int unsigned FRAME_STEPS = 840,
    parameter int unsigned CNT_W       = $clog2(FRAME_STEPS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic in_valid,
    output logic take_sample,
    output logic tail_step,
    output logic fin_pulse
);
    localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(SEQ_LEN);
    localparam logic [CNT_W-1:0] LAST_STEP   = CNT_W'(FRAME_STEPS);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        s_d         = s_q;
        take_sample = 1'b0;
        tail_step   = 1'b0;
        fin_pulse   = 1'b0;
        cnt_inc     = s_q.cnt + ONE;
        if (sof) begin
            s_d.st  = SEQ_RUN;
            s_d.cnt = '0;
            if (in_valid) begin
                take_sample = 1'b1;
                s_d.cnt     = ONE;
                if (LAST_SAMPLE == ONE) s_d.st = SEQ_TAIL;
            end
        end else begin
            case (s_q.st)
                SEQ_RUN: begin
                    if (in_valid) begin
                        take_sample = 1'b1;
                        s_d.cnt     = cnt_inc;
                        if (cnt_inc == LAST_SAMPLE) s_d.st = SEQ_TAIL;
                    end
                end
                SEQ_TAIL: begin
                    tail_step = 1'b1;
                    s_d.cnt   = cnt_inc;
                    if (cnt_inc == LAST_STEP) s_d.st = SEQ_FIN;
                end
                SEQ_FIN: begin
                    fin_pulse = 1'b1;
                    s_d.st    = SEQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= SEQ_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dspk_encoder.sv
module dspk_encoder #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned N_CH        = 80,
    parameter int unsigned SEQ_LEN     = 784,
    parameter int unsigned FRAME_STEPS = 840
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              spk_valid,
    output logic [N_CH-1:0]   spk,
    output logic              frame_done
);
    localparam int unsigned N_LVL = N_CH - 1;

    typedef struct packed {
        logic [DATA_W-1:0] prev;
        logic              vld;
        logic [N_CH-1:0]   spk;
        logic              done;
    } enc_t;

    enc_t e_d, e_q;

    logic              take_sample, tail_step, fin_pulse;
    logic [DATA_W-1:0] base, lo, hi;
    logic              up;
    logic [N_LVL-1:0]  hit;

    dspk_seq #(
        .SEQ_LEN    (SEQ_LEN),
        .FRAME_STEPS(FRAME_STEPS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .in_valid   (in_valid),
        .take_sample(take_sample),
        .tail_step  (tail_step),
        .fin_pulse  (fin_pulse)
    );

    // A start of frame makes the comparison reference zero in the same cycle.
    always_comb begin
        base = sof ? '0 : e_q.prev;
        up   = in_sample > base;
        lo   = up ? base : in_sample;
        hi   = up ? in_sample : base;
    end

    dspk_ladder #(
        .DATA_W(DATA_W),
        .N_LVL (N_LVL)
    ) u_ladder (
        .lo (lo),
        .hi (hi),
        .up (up),
        .hit(hit)
    );

    always_comb begin
        e_d      = e_q;
        e_d.vld  = 1'b0;
        e_d.spk  = '0;
        e_d.done = fin_pulse;
        if (sof) e_d.prev = '0;
        if (take_sample) begin
            e_d.prev = in_sample;
            e_d.vld  = 1'b1;
            e_d.spk  = {1'b0, hit};
        end
        if (tail_step) begin
            e_d.vld  = 1'b1;
            e_d.spk  = {1'b1, {N_LVL{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign spk_valid  = e_q.vld;
    assign spk        = e_q.spk;
    assign frame_done = e_q.done;

endmodule

// File: rtl/dspk_encoder_chk.sv
module dspk_encoder_chk #(
    parameter int unsigned N_CH = 80
) (
    input logic            clk,
    input logic            rst_n,
    input logic            spk_valid,
    input logic [N_CH-1:0] spk,
    input logic            frame_done
);
    logic [N_CH-2:0] even_m;
    for (genvar g = 0; g < N_CH - 1; g++) begin : g_even
        assign even_m[g] = ((g % 2) == 0);
    end

    AST_QUIET_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_valid |-> (spk == '0)); // R7
    AST_END_MARK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_valid && spk[N_CH-1]) |-> (spk[N_CH-2:0] == '0)); // R8
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        spk_valid |-> (((spk[N_CH-2:0] & even_m) == '0) || ((spk[N_CH-2:0] & ~even_m) == '0))); // R11
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(spk_valid && spk[N_CH-1])); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9
    AST_DONE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !spk_valid); // R9
    AST_RUNG0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !spk[0]); // R2

endmodule

bind dspk_encoder dspk_encoder_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spk_valid (spk_valid),
    .spk       (spk),
    .frame_done(frame_done)
);

// File: tb/sim_dspk_encoder.sv
module sim_dspk_encoder;
    localparam int NCH = 80;
    localparam int SEQ = 784;
    localparam int FRS = 840;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sof = 1'b0;
    logic           in_valid = 1'b0;
    logic [7:0]     in_sample = 8'd0;
    logic           spk_valid;
    logic [NCH-1:0] spk;
    logic           frame_done;

    always #2 clk = ~clk;

    dspk_encoder u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid),
        .in_sample(in_sample), .spk_valid(spk_valid), .spk(spk), .frame_done(frame_done)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference model state: 0 idle, 1 sampling, 2 tail, 3 done pending
    int             m_st = 0;
    int             m_cnt = 0;
    int             m_prev = 0;
    bit             seen_sof = 0;
    logic           exp_v = 1'b0;
    logic [NCH-1:0] exp_s = '0;
    logic           exp_d = 1'b0;
    string          tag = "R1";
    string          force_tag = "";

    function automatic logic [NCH-2:0] xing(int p, int x);
        logic [NCH-2:0] r = '0;
        for (int k = 0; k < NCH - 1; k++) begin
            int t = (k * 256) / (NCH - 1);
            if (x > p && (k % 2) == 0 && t > p && t <= x) r[k] = 1'b1;
            if (x < p && (k % 2) == 1 && t > x && t <= p) r[k] = 1'b1;
        end
        return r;
    endfunction

    task automatic check();
        logic [NCH-2:0] even_m;
        n_chk++;
        if (spk_valid !== exp_v || spk !== exp_s || frame_done !== exp_d) begin
            n_err++;
            $display("FAIL %s: actual valid=%0b spk=%h done=%0b expected valid=%0b spk=%h done=%0b",
                     tag, spk_valid, spk, frame_done, exp_v, exp_s, exp_d);
        end
        if (spk_valid === 1'b1) begin
            for (int k = 0; k < NCH - 1; k++) even_m[k] = ((k % 2) == 0);
            n_chk++;
            if ((spk[NCH-2:0] & even_m) != '0 && (spk[NCH-2:0] & ~even_m) != '0) begin
                n_err++;
                $display("FAIL R11: actual spk=%h expected one direction only", spk);
            end
        end
    endtask

    task automatic model(bit r, bit s, bit v, int x);
        exp_v = 1'b0; exp_s = '0; exp_d = 1'b0;
        if (!r) begin
            m_st = 0; m_cnt = 0; m_prev = 0; tag = "R1";
        end else if (s) begin
            tag = (m_st == 1 || m_st == 2) ? "R10" : "R6";
            m_st = 1; m_cnt = 0; m_prev = 0; seen_sof = 1;
            if (v) begin
                exp_v = 1'b1; exp_s = {1'b0, xing(0, x)};
                m_prev = x; m_cnt = 1;
            end
        end else begin
            case (m_st)
                1: if (v) begin
                       exp_v = 1'b1; exp_s = {1'b0, xing(m_prev, x)};
                       tag = (x > m_prev) ? "R3" : (x < m_prev) ? "R4" : "R5";
                       m_prev = x; m_cnt++;
                       if (m_cnt == SEQ) m_st = 2;
                   end else tag = "R7";
                2: begin
                       exp_v = 1'b1; exp_s[NCH-1] = 1'b1; tag = "R8";
                       m_cnt++;
                       if (m_cnt == FRS) m_st = 3;
                   end
                3: begin exp_d = 1'b1; m_st = 0; tag = "R9"; end
                default: tag = seen_sof ? "R9" : "R1";
            endcase
        end
        if (force_tag != "") tag = force_tag;
    endtask

    task automatic tick(bit r, bit s, bit v, int x);
        @(negedge clk);
        if (!finished) check();
        rst_n = r; sof = s; in_valid = v; in_sample = x[7:0];
        model(r, s, v, x);
    endtask

    function automatic int next_val();
        int d;
        if ($urandom_range(0, 3) == 0) return $urandom_range(0, 255);
        d = m_prev + $urandom_range(0, 40) - 20;
        if (d < 0) d = 0;
        if (d > 255) d = 255;
        return d;
    endfunction

    task automatic run_to_idle();
        while (m_st != 0) tick(1, 0, ($urandom_range(0, 3) != 0), next_val());
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        void'($urandom(32'd7031));
        // R1: reset state, then samples before any sof are ignored
        for (int i = 0; i < 4; i++) tick(0, 0, 1, 9);
        for (int i = 0; i < 3; i++) tick(1, 0, 1, 50);
        // R2: directed threshold boundaries
        force_tag = "R2";
        tick(1, 1, 1, 3);     // threshold 3 belongs to falling rung 1: nothing
        tick(1, 0, 1, 6);     // rung 2 (level 6) fires, 6 <= 6
        tick(1, 0, 1, 2);     // rung 1 (level 3) fires on the way down
        tick(1, 0, 1, 2);     // unchanged
        tick(1, 0, 1, 255);   // every even rung from 2 to 78
        tick(1, 0, 1, 0);     // every odd rung from 1 to 77
        force_tag = "";
        run_to_idle();        // R3, R4, R5, R7, R8
        for (int i = 0; i < 5; i++) tick(1, 0, 1, 77);   // R9: ignored after done
        // R6: sof without sample, then first sample compared to zero
        tick(1, 1, 0, 0);
        tick(1, 0, 1, 130);
        for (int i = 0; i < 100; i++) tick(1, 0, 1, next_val());
        tick(1, 1, 1, 200);   // R10: restart mid-frame
        run_to_idle();
        tick(1, 0, 1, 12);
        tick(1, 0, 0, 0);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL R7: watchdog expired, actual=hung expected=run complete");
            summary();
            $finish;
        end
    end

endmodule